// File: doc/BRIEF.md
# Real-Time Clock Core with Tick-Synchronised Register Writes

This block keeps wall-clock time as a single packed 32-bit word holding a day count, hours, minutes and seconds. It is driven by a 32.768 kHz tick enable. An optional divider reduces that tick to one count per second. With the divider bypassed, the count advances on every raw tick.

Software-facing writes do not land directly. A write to the time, alarm or control register is captured in a single shadow slot and raises a pending flag. The value is committed only on the next counting tick. At that point a one-cycle completion pulse is produced. While the slot is occupied, every further write is thrown away. Software is therefore expected to wait for the completion pulse, or for pending to fall, before writing again.

The counter produces one-cycle event pulses for every second step and for each rollover of seconds, minutes and hours. A read port returns the live time or the committed alarm and control values. Calendar conversion and interrupt masking belong to other blocks.

Top module: `rtc_shadow_core`

## Requirements
- R1: `time_o` packs seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and days in bits 31:17. Each counting tick that does not commit a time write adds one second.
- R2: Seconds at 59 or above wrap to 0 and carry into minutes. Minutes at 59 or above wrap to 0 and carry into hours. Hours at 23 or above wrap to 0 and carry into days.
- R3: A carry into a day field of 32767 wraps the day field to 0.
- R4: With control bit 0 at 0 (divider off), every cycle with `tick_i` high is a counting tick.
- R5: With control bit 0 at 1 (divider on), only every DIV-th `tick_i` is a counting tick. The divider starts from zero when it is switched on.
- R6: A write with `wr_sel_i` 0 (time), 1 (alarm) or 2 (control) is accepted when nothing is pending. `wr_pending_o` rises the next cycle and the target register keeps its old value. On the next counting tick the value is committed, `wr_pending_o` falls and `wr_done_o` is high for exactly one cycle.
- R7: A write issued while a write is pending has no effect. This includes a write in the same cycle as the commit.
- R8: When a time write commits on a counting tick, `time_o` becomes exactly the written value. No second is added on that tick, and no event pulses are produced.
- R9: `sec_evt_o` pulses one cycle after each counting tick that advances time. `min_evt_o`, `hour_evt_o` and `day_evt_o` pulse in the same cycle when the seconds, minutes and hours fields wrap, respectively.
- R10: After reset, time is 0, alarm is 0, control is 0 (divider off), nothing is pending and no pulse is high.
- R11: `rd_data_o` returns the live time for `rd_sel_i` 0, the committed alarm for 1, control bit 0 zero-extended for 2, and 0 for 3. A write with `wr_sel_i` 3 is ignored and sets nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 32.768 kHz tick enable, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 time, 1 alarm, 2 control, 3 none |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read source, same encoding as `wr_sel_i` |
| rd_data_o | output | 32 | Read data |
| time_o | output | 32 | Live packed time word |
| wr_pending_o | output | 1 | A write waits in the shadow slot |
| wr_done_o | output | 1 | One-cycle pulse when a write commits |
| sec_evt_o | output | 1 | Second-advance pulse |
| min_evt_o | output | 1 | Seconds-wrap pulse |
| hour_evt_o | output | 1 | Minutes-wrap pulse |
| day_evt_o | output | 1 | Hours-wrap pulse |

## Verification
The bench targets the three collisions that matter in this block:

- **Time commit landing on a counting tick.** A design that let the increment win would show the written time plus one second.
- **Second write in the same cycle as a commit.** A design that freed the slot a cycle early would commit the second value instead of dropping it.
- **Full-carry chain at day 32767, 23:59:59.** A wrong wrap would leave a non-zero word, or would lose the day pulse.

The bench also switches the divider on and counts the exact number of raw ticks before the first advance. A divider that failed to restart, or that stopped one step early, would advance time at the wrong tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned SEC_W  = 6;
  localparam int unsigned MIN_W  = 6;
  localparam int unsigned HOUR_W = 5;
  localparam int unsigned DAY_W  = 15;
  localparam int unsigned WORD_W = SEC_W + MIN_W + HOUR_W + DAY_W;

  localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(59);
  localparam logic [MIN_W-1:0]  MIN_LAST  = MIN_W'(59);
  localparam logic [HOUR_W-1:0] HOUR_LAST = HOUR_W'(23);
  localparam logic [DAY_W-1:0]  DAY_LAST  = '1;

  // Field order is the word layout seen by neighbours: days high, seconds low.
  typedef struct packed {
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } rtc_word_t;

  typedef enum logic [1:0] {
    TGT_TIME  = 2'd0,
    TGT_ALARM = 2'd1,
    TGT_CTRL  = 2'd2,
    TGT_NONE  = 2'd3
  } rtc_target_e;

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic div_en_i,
  output logic count_tick_o
);

  localparam int unsigned DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             div_ce;
  logic             at_top;

  assign at_top       = (div_q == DIV_TOP);
  assign count_tick_o = tick_i & (~div_en_i | at_top);

  always_comb begin
    div_ce = 1'b0;
    div_d  = div_q;
    if (!div_en_i) begin
      div_ce = (div_q != '0);
      div_d  = '0;
    end else if (tick_i) begin
      div_ce = 1'b1;
      div_d  = at_top ? '0 : div_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (div_ce) begin
      div_q <= div_d;
    end
  end

  // R5: divider never leaves its range
  a_r5_div_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= DIV_TOP);

  // R4: with the divider off every raw tick counts
  a_r4_free_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div_en_i && tick_i) |-> count_tick_o);

  // R5: a counting tick always stems from a raw tick
  a_r5_tick_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_tick_o |-> tick_i);

endmodule

// File: rtl/rtc_wr_shadow.sv
module rtc_wr_shadow
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              count_tick_i,
  output logic              pending_o,
  output logic              done_o,
  output logic              commit_o,
  output rtc_target_e       commit_tgt_o,
  output logic [WORD_W-1:0] commit_data_o
);

  logic              pend_q, pend_d;
  logic              done_q, done_d;
  rtc_target_e       tgt_q;
  logic [WORD_W-1:0] data_q;
  logic              accept;
  logic              commit;

  assign commit = pend_q & count_tick_i;
  assign accept = wr_en_i & ~pend_q & (rtc_target_e'(wr_sel_i) != TGT_NONE);

  always_comb begin
    pend_d = pend_q;
    if (commit) begin
      pend_d = 1'b0;
    end else if (accept) begin
      pend_d = 1'b1;
    end
    done_d = commit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= TGT_NONE;
      data_q <= '0;
    end else if (accept) begin
      tgt_q  <= rtc_target_e'(wr_sel_i);
      data_q <= wr_data_i;
    end
  end

  assign pending_o     = pend_q;
  assign done_o        = done_q;
  assign commit_o      = commit;
  assign commit_tgt_o  = tgt_q;
  assign commit_data_o = data_q;

  // R6: completion pulse only right after a pending slot drained
  a_r6_done_after_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!pend_q && $past(pend_q)));

  // R6: pending holds until a counting tick
  a_r6_wait_for_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !count_tick_i) |=> pend_q);

  // R7: shadow contents frozen while occupied
  a_r7_slot_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && $past(pend_q)) |-> ($stable(data_q) && $stable(tgt_q)));

endmodule

// File: rtl/rtc_time_count.sv
module rtc_time_count
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      step_i,
  input  logic      load_i,
  input  rtc_word_t load_val_i,
  output rtc_word_t time_o,
  output logic      sec_evt_o,
  output logic      min_evt_o,
  output logic      hour_evt_o,
  output logic      day_evt_o
);

  rtc_word_t time_q, time_d;
  logic      time_ce;
  logic      sec_d, min_d, hour_d, day_d;
  logic      sec_q, min_q, hour_q, day_q;

  always_comb begin
    time_d  = time_q;
    time_ce = load_i | step_i;
    sec_d   = 1'b0;
    min_d   = 1'b0;
    hour_d  = 1'b0;
    day_d   = 1'b0;
    if (load_i) begin
      time_d = load_val_i;
    end else if (step_i) begin
      sec_d = 1'b1;
      if (time_q.sec >= SEC_LAST) begin
        time_d.sec = '0;
        min_d      = 1'b1;
        if (time_q.min >= MIN_LAST) begin
          time_d.min = '0;
          hour_d     = 1'b1;
          if (time_q.hour >= HOUR_LAST) begin
            time_d.hour = '0;
            day_d       = 1'b1;
            time_d.day  = (time_q.day == DAY_LAST) ? '0 : time_q.day + 1'b1;
          end else begin
            time_d.hour = time_q.hour + 1'b1;
          end
        end else begin
          time_d.min = time_q.min + 1'b1;
        end
      end else begin
        time_d.sec = time_q.sec + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
    end else if (time_ce) begin
      time_q <= time_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 1'b0;
      min_q  <= 1'b0;
      hour_q <= 1'b0;
      day_q  <= 1'b0;
    end else begin
      sec_q  <= sec_d;
      min_q  <= min_d;
      hour_q <= hour_d;
      day_q  <= day_d;
    end
  end

  assign time_o     = time_q;
  assign sec_evt_o  = sec_q;
  assign min_evt_o  = min_q;
  assign hour_evt_o = hour_q;
  assign day_evt_o  = day_q;

  // R9: rollover pulses nest inside each other
  a_r9_min_needs_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_q |-> sec_q);
  a_r9_hour_needs_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hour_q |-> min_q);
  a_r9_day_needs_hour: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_q |-> hour_q);

  // R2: a seconds wrap leaves seconds at zero
  a_r2_sec_wrapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_q |-> (time_q.sec == '0));

  // R1: a plain step adds exactly one second
  a_r1_sec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_q && !min_q) |-> (time_q.sec == $past(time_q.sec) + 1'b1));

  // R3: the top day value wraps to zero
  a_r3_day_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (day_q && ($past(time_q.day) == DAY_LAST)) |-> (time_q.day == '0));

  // R8: a load lands unchanged with no event
  a_r8_load_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> ((time_q == $past(load_val_i)) && !sec_q));

endmodule

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  rtc_target_e       commit_tgt_i,
  input  logic [WORD_W-1:0] commit_data_i,
  input  logic [1:0]        rd_sel_i,
  input  rtc_word_t         time_i,
  output logic              div_en_o,
  output logic [WORD_W-1:0] rd_data_o
);

  logic [WORD_W-1:0] alarm_q;
  logic              div_en_q;
  logic              alarm_ce, ctrl_ce;

  assign alarm_ce = commit_i & (commit_tgt_i == TGT_ALARM);
  assign ctrl_ce  = commit_i & (commit_tgt_i == TGT_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '0;
    end else if (alarm_ce) begin
      alarm_q <= commit_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_en_q <= 1'b0;
    end else if (ctrl_ce) begin
      div_en_q <= commit_data_i[0];
    end
  end

  always_comb begin
    unique case (rtc_target_e'(rd_sel_i))
      TGT_TIME:  rd_data_o = time_i;
      TGT_ALARM: rd_data_o = alarm_q;
      TGT_CTRL:  rd_data_o = {{(WORD_W-1){1'b0}}, div_en_q};
      default:   rd_data_o = '0;
    endcase
  end

  assign div_en_o = div_en_q;

  // R11: committed registers only move on a matching commit
  a_r11_alarm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(alarm_ce) |-> $stable(alarm_q));
  a_r11_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ctrl_ce) |-> $stable(div_en_q));

endmodule

// File: rtl/rtc_shadow_core.sv
module rtc_shadow_core
  import rtc_pkg::*;
#(
  parameter int unsigned DIV = 32768
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic [1:0]  rd_sel_i,
  output logic [31:0] rd_data_o,
  output logic [31:0] time_o,
  output logic        wr_pending_o,
  output logic        wr_done_o,
  output logic        sec_evt_o,
  output logic        min_evt_o,
  output logic        hour_evt_o,
  output logic        day_evt_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  logic              count_tick;
  logic              div_en;
  logic              commit;
  rtc_target_e       commit_tgt;
  logic [WORD_W-1:0] commit_data;
  logic              load_time;
  logic              step_time;
  rtc_word_t         time_w;

  rtc_prescale #(.DIV(DIV)) u_prescale (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .tick_i       (tick_i),
    .div_en_i     (div_en),
    .count_tick_o (count_tick)
  );

  rtc_wr_shadow u_shadow (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .wr_en_i       (wr_en_i),
    .wr_sel_i      (wr_sel_i),
    .wr_data_i     (wr_data_i),
    .count_tick_i  (count_tick),
    .pending_o     (wr_pending_o),
    .done_o        (wr_done_o),
    .commit_o      (commit),
    .commit_tgt_o  (commit_tgt),
    .commit_data_o (commit_data)
  );

  // A committed time write takes the tick; the increment is skipped.
  assign load_time = commit & (commit_tgt == TGT_TIME);
  assign step_time = count_tick & ~load_time;

  rtc_time_count u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .step_i     (step_time),
    .load_i     (load_time),
    .load_val_i (rtc_word_t'(commit_data)),
    .time_o     (time_w),
    .sec_evt_o  (sec_evt_o),
    .min_evt_o  (min_evt_o),
    .hour_evt_o (hour_evt_o),
    .day_evt_o  (day_evt_o)
  );

  rtc_cfg_regs u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .commit_i      (commit),
    .commit_tgt_i  (commit_tgt),
    .commit_data_i (commit_data),
    .rd_sel_i      (rd_sel_i),
    .time_i        (time_w),
    .div_en_o      (div_en),
    .rd_data_o     (rd_data_o)
  );

  assign time_o = time_w;

  // R7: a write while pending never restarts the slot
  a_r7_drop_while_busy: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_pending_o && !count_tick) |=> (wr_pending_o && !wr_done_o));

  // R10: nothing moves without a tick
  a_r10_idle_time: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$past(count_tick) |-> ($stable(time_o) && !sec_evt_o && !wr_done_o));

endmodule

// File: tb/rtc_shadow_core_bench.sv
module rtc_shadow_core_bench;

  localparam int DIV = 8;

  logic        clk, rst_n;
  logic        tick, wen;
  logic [1:0]  wsel, rsel;
  logic [31:0] wdata, rdata, tword;
  logic        pend, done, sev, mev, hev, dev;

  rtc_shadow_core #(.DIV(DIV)) u_rtc_shadow_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wen),
    .wr_sel_i(wsel), .wr_data_i(wdata), .rd_sel_i(rsel), .rd_data_o(rdata),
    .time_o(tword), .wr_pending_o(pend), .wr_done_o(done),
    .sec_evt_o(sev), .min_evt_o(mev), .hour_evt_o(hev), .day_evt_o(dev)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit live = 0;

  // behavioural reference state
  int m_sec, m_min, m_hr, m_day, m_div;
  logic [31:0] m_alarm, m_data;
  int m_ctrl, m_sel;
  bit m_pend, m_done, m_se, m_me, m_he, m_de;

  function automatic logic [31:0] pack(int d, int h, int m, int s);
    return (32'(d) << 17) | (32'(h) << 12) | (32'(m) << 6) | 32'(s);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit ct, cm, ldt;
    cycles++;
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_div = 0;
      m_alarm = 0; m_data = 0; m_ctrl = 0; m_sel = 3;
      m_pend = 0; m_done = 0; m_se = 0; m_me = 0; m_he = 0; m_de = 0;
    end else begin
      ct = tick && (m_ctrl == 0 || m_div == DIV - 1);
      cm = m_pend && ct;
      if (m_ctrl == 0) m_div = 0;
      else if (tick) m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
      m_se = 0; m_me = 0; m_he = 0; m_de = 0;
      m_done = cm;
      ldt = cm && m_sel == 0;
      if (cm) begin
        m_pend = 0;
        if (m_sel == 0) begin
          m_sec = int'(m_data[5:0]); m_min = int'(m_data[11:6]);
          m_hr = int'(m_data[16:12]); m_day = int'(m_data[31:17]);
        end else if (m_sel == 1) m_alarm = m_data;
        else m_ctrl = int'(m_data[0]);
      end
      if (ct && !ldt) begin
        m_se = 1;
        if (m_sec >= 59) begin
          m_sec = 0; m_me = 1;
          if (m_min >= 59) begin
            m_min = 0; m_he = 1;
            if (m_hr >= 23) begin
              m_hr = 0; m_de = 1;
              m_day = (m_day == 32767) ? 0 : m_day + 1;
            end else m_hr++;
          end else m_min++;
        end else m_sec++;
      end
      if (wen && !(m_pend || cm) && wsel != 2'd3) begin
        m_pend = 1; m_sel = int'(wsel); m_data = wdata;
      end
    end
  end

  // every-cycle comparison, away from the clock edge
  always @(posedge clk) begin
    #2;
    if (live) begin
      logic [31:0] exp_rd;
      case (rsel)
        2'd0: exp_rd = pack(m_day, m_hr, m_min, m_sec);
        2'd1: exp_rd = m_alarm;
        2'd2: exp_rd = 32'(m_ctrl);
        default: exp_rd = 0;
      endcase
      chk("R1 time word", tword, pack(m_day, m_hr, m_min, m_sec));
      chk("R6 pending", 32'(pend), 32'(m_pend));
      chk("R6 done", 32'(done), 32'(m_done));
      chk("R9 events", {28'd0, dev, hev, mev, sev}, {28'd0, m_de, m_he, m_me, m_se});
      chk("R11 read", rdata, exp_rd);
    end
  end

  task automatic cyc(bit t, bit w, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    tick = t; wen = w; wsel = s; wdata = d;
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  initial begin
    if (cycles > 100000) ;
    forever begin
      @(posedge clk);
      if (cycles > 100000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] t0;
    rst_n = 0; tick = 0; wen = 0; wsel = 0; wdata = 0; rsel = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) cyc(0, 0, 0, 0);
    settle();
    live = 1;
    // R10 reset state
    chk("R10 time", tword, 0);
    chk("R10 pending", 32'(pend), 0);
    rsel = 2'd2; cyc(0, 0, 0, 0); settle();
    chk("R10 ctrl", rdata, 0);
    rsel = 2'd1; cyc(0, 0, 0, 0); settle();
    chk("R10 alarm", rdata, 0);
    rsel = 2'd0;
    // R4 free counting
    repeat (10) cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0); settle();
    chk("R4 ten ticks", tword, 10);
    repeat (130) cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0); settle();
    chk("R2 minute carry", tword, pack(0, 0, 2, 20));
    // R6/R7/R8 time write
    cyc(0, 1, 2'd0, pack(5, 23, 59, 50)); settle();
    chk("R6 pending set", 32'(pend), 1);
    chk("R6 old time kept", tword, pack(0, 0, 2, 20));
    cyc(0, 1, 2'd0, pack(1, 1, 1, 1)); settle();
    chk("R7 dropped keeps time", tword, pack(0, 0, 2, 20));
    cyc(1, 0, 0, 0); settle();
    chk("R8 commit exact", tword, pack(5, 23, 59, 50));
    chk("R6 done pulse", 32'(done), 1);
    chk("R8 no event on load", 32'(sev), 0);
    repeat (12) cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0); settle();
    chk("R2 day carry", tword, pack(6, 0, 0, 2));
    // R3 day wrap
    cyc(0, 1, 2'd0, pack(32767, 23, 59, 59));
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0); settle();
    chk("R3 wrap to zero", tword, 0);
    chk("R3 day event", 32'(dev), 1);
    // R7 write on commit cycle
    cyc(0, 1, 2'd1, 32'h0000_ABCD);
    cyc(1, 1, 2'd1, 32'h1234_5678); settle();
    chk("R7 pending after clash", 32'(pend), 0);
    rsel = 2'd1; cyc(0, 0, 0, 0); settle();
    chk("R7 alarm keeps first", rdata, 32'h0000_ABCD);
    // R11 ignored target
    cyc(0, 1, 2'd3, 32'hFFFF_FFFF); settle();
    chk("R11 sel3 ignored", 32'(pend), 0);
    rsel = 2'd3; cyc(0, 0, 0, 0); settle();
    chk("R11 sel3 reads zero", rdata, 0);
    // R5 divider
    rsel = 2'd2;
    cyc(0, 1, 2'd2, 32'd1);
    cyc(1, 0, 0, 0); settle();
    chk("R11 ctrl readback", rdata, 1);
    t0 = tword;
    repeat (DIV - 1) cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0); settle();
    chk("R5 no advance before DIV", tword, t0);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0); settle();
    chk("R5 advance at DIV", tword, t0 + 1);
    rsel = 2'd0;
    cyc(0, 1, 2'd0, pack(3, 4, 5, 6));
    repeat (DIV / 2) cyc(1, 0, 0, 0);
    settle();
    chk("R6 waits for divided tick", 32'(pend), 1);
    repeat (3 * DIV) cyc(1, 0, 0, 0);
    // irregular traffic
    for (int i = 0; i < 300; i++) begin
      cyc(i % 3 == 0, i % 17 == 5, 2'(i % 4), 32'(i * 32'h0001_0041));
      rsel = 2'(i % 4);
    end
    cyc(0, 1, 2'd2, 32'd0);
    repeat (2 * DIV) cyc(1, 0, 0, 0);
    for (int i = 0; i < 200; i++) cyc(i % 2 == 0, i % 11 == 3, 2'd0, pack(i, 23, 59, 57));
    cyc(0, 0, 0, 0); settle();
    live = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule